// File: doc/BRIEF.md
# Parallel Configuration Loader

This block is the master side of a byte-wide slave parallel configuration link to a programmable logic device. After a start pulse it pulls the target's configuration-reset line low, waits for the target to report that its configuration memory is being cleared, then releases the reset. It waits for the target to signal that it is ready, selects the target for writing and lets the link settle. After that it moves one byte per configuration-clock cycle from a valid/ready byte stream onto the data bus.

During the data phase, a falling init line means that the target found a corrupt bitstream, typically a CRC mismatch. The loader then aborts at once. After the byte marked last it deselects the target and waits for the target to report a finished, error-free start-up. Every waiting phase has its own timeout. All pulse widths, settling delays and timeouts are given in time units and turned into cycle counts from a single clock-frequency parameter. The three status lines coming back from the target pass through a synchronizer before the controller reads them. The result is held on a success flag, or on an error flag with a cause code, until the next start.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held and right after it, cfg_rst_n, cfg_clk, cfg_sel_n and cfg_wr_n are high, s_ready is low, and ld_active, ld_ok, ld_err are low with ld_cause = 0.
- R2: A start in idle drives cfg_rst_n low for at least the minimum pulse width (PROG_NS) and until the synchronized cfg_init_n has been seen low. If cfg_init_n is not seen low within INIT_TMO_US of the pulse start, the load aborts with cause 1.
- R3: After cfg_rst_n is released, the loader waits for cfg_init_n high and cfg_busy low. If they are not both seen within INIT_TMO_US, the load aborts with cause 2.
- R4: cfg_sel_n and cfg_wr_n fall together. At least SETTLE_US worth of cycles pass before cfg_clk first goes low.
- R5: s_ready is high only in the data phase while cfg_init_n is high. Each accepted byte is placed on cfg_data in the cycle cfg_clk goes low. cfg_clk stays low for exactly one cycle, and the data is held through the rising edge. Bytes reach the target in stream order.
- R6: If cfg_init_n goes low during the data phase (including the wait after a byte), the load aborts with cause 3.
- R7: With CHECK_BUSY set, after each byte the loader waits at least SYNC_STAGES cycles and then until cfg_busy is low. If cfg_busy stays high for BUSY_TMO_US, the load aborts with cause 4.
- R8: After the byte with s_last, cfg_sel_n rises, and cfg_wr_n rises exactly one cycle later. ld_ok is set once cfg_done and cfg_init_n are both high. If that does not happen within DONE_TMO_US, the load aborts with cause 5.
- R9: On any abort, cfg_rst_n, cfg_sel_n and cfg_wr_n return high, and ld_err with ld_cause is held until the next start, which clears them. The cause codes are: 1 init-assert timeout, 2 init-release timeout, 3 load error, 4 busy timeout, 5 done timeout. ld_ok and ld_err are never both set.
- R10: A start pulse while ld_active is high is ignored: no second reset pulse and no change to the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a configuration run (taken only when idle) |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | Current byte is the final one |
| s_ready | output | 1 | Loader takes the byte this cycle |
| cfg_rst_n | output | 1 | Target configuration reset, active low |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_sel_n | output | 1 | Target chip select, active low |
| cfg_wr_n | output | 1 | Target write enable, active low |
| cfg_data | output | 8 | Byte bus to the target |
| cfg_init_n | input | 1 | Target init/error line, low while clearing or on error |
| cfg_busy | input | 1 | Target cannot accept a byte |
| cfg_done | input | 1 | Target finished start-up |
| ld_active | output | 1 | A run is in progress |
| ld_ok | output | 1 | Last run succeeded |
| ld_err | output | 1 | Last run aborted |
| ld_cause | output | 3 | Abort cause code (R9) |

## Verification
A behavioural target model answers the loader and can be steered into a different misbehaviour for each run. The runs cover healthy loads of one, several and nine bytes. The nine-byte run adds a busy pause after every byte, which separates waiting on busy from simply pacing the clock. Fault runs cover an init line that never falls, one that never rises again, a CRC fault raised after the second byte, a busy line stuck high and a done line that never comes. Each fault must produce its own cause code, the right count of bytes delivered and idle pins. On healthy runs the bench also measures the reset pulse width, the settle gap and the order of the deselect edges.

// File: rtl/cfg_ld_pkg.sv
// Package: shared types for the parallel configuration loader.
// Holds the controller state encoding and the abort cause codes.
// Assumes nothing beyond IEEE 1800-2017.
package cfg_ld_pkg;

    // Controller phases, in the order a healthy run walks them.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_REL,
        ST_SETTLE,
        ST_LOAD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_BWAIT,
        ST_DESEL,
        ST_UNWR,
        ST_DWAIT
    } ld_state_t;

    // Abort causes as seen on ld_cause.
    typedef enum logic [2:0] {
        CAUSE_NONE         = 3'd0,
        CAUSE_INIT_ASSERT  = 3'd1,
        CAUSE_INIT_RELEASE = 3'd2,
        CAUSE_LOAD_ERR     = 3'd3,
        CAUSE_BUSY         = 3'd4,
        CAUSE_DONE         = 3'd5
    } ld_cause_t;

    // Number of clock cycles in a span given in microseconds.
    function automatic int unsigned us_to_cyc(int unsigned hz, int unsigned us);
        return (hz / 1_000_000) * us;
    endfunction

    // Number of clock cycles in a span given in nanoseconds, rounded up.
    function automatic int unsigned ns_to_cyc(int unsigned hz, int unsigned ns);
        return ((hz / 1_000_000) * ns + 999) / 1000;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
// Module: multi-bit level synchronizer.
// Each input bit passes through STAGES flip-flops. Assumes the inputs
// are slow levels, so bits may resolve in different cycles.
module cfg_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    // Remaining stages form the resolution chain.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_timer.sv
// Module: phase timer.
// Counts clock cycles since the last clear and saturates at all-ones.
// The controller clears it on every phase entry and compares the count.
module cfg_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);

    // Saturating up-count, restarted by clr.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (cnt != '1)    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cfg_fsm.sv
// Module: configuration sequencing controller.
// Walks reset pulse, init handshakes, settle, byte transfer, optional
// busy wait and done check. Aborts on timeout or init error. Pin outputs
// are registered from the next state so they never glitch.
// Assumes init_ok/busy_s/done_s are already synchronized.
module cfg_fsm
    import cfg_ld_pkg::*;
#(
    parameter int          DW          = 8,
    parameter int          TW          = 8,
    parameter int unsigned PROG_CYC    = 30,
    parameter int unsigned INIT_CYC    = 300,
    parameter int unsigned SETTLE_CYC  = 100,
    parameter int unsigned BUSY_CYC    = 100,
    parameter int unsigned DONE_CYC    = 200,
    parameter int unsigned SYNC_CYC    = 2,
    parameter bit          CHECK_BUSY  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    input  logic          init_ok,
    input  logic          busy_s,
    input  logic          done_s,
    input  logic [TW-1:0] tcnt,
    output logic          tclr,
    output logic          cfg_rst_n,
    output logic          cfg_clk,
    output logic          cfg_sel_n,
    output logic          cfg_wr_n,
    output logic [DW-1:0] cfg_data,
    output logic          ld_active,
    output logic          ld_ok,
    output logic          ld_err,
    output logic [2:0]    ld_cause
);

    localparam logic [TW-1:0] L_PROG   = TW'(PROG_CYC);
    localparam logic [TW-1:0] L_INIT   = TW'(INIT_CYC);
    localparam logic [TW-1:0] L_SETTLE = TW'(SETTLE_CYC);
    localparam logic [TW-1:0] L_BUSY   = TW'(BUSY_CYC);
    localparam logic [TW-1:0] L_DONE   = TW'(DONE_CYC);
    localparam logic [TW-1:0] L_SYNC   = TW'(SYNC_CYC);

    ld_state_t st, st_n;
    ld_cause_t cause_q, fin_cause;
    logic      fin_ok, fin_err, accept, launch, last_q;

    // Phases in which the target is selected / write-enabled.
    function automatic logic sel_on(ld_state_t s);
        return (s == ST_SETTLE) || (s == ST_LOAD) || (s == ST_CLK_LO) ||
               (s == ST_CLK_HI) || (s == ST_BWAIT);
    endfunction

    function automatic logic wr_on(ld_state_t s);
        return sel_on(s) || (s == ST_DESEL);
    endfunction

    assign s_ready = (st == ST_LOAD) && init_ok;
    assign accept  = s_ready && s_valid;

    // Next-state, timer restart and run-outcome decode.
    always_comb begin
        st_n      = st;
        tclr      = 1'b0;
        fin_ok    = 1'b0;
        fin_err   = 1'b0;
        fin_cause = CAUSE_NONE;
        launch    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    st_n   = ST_PULSE;
                    tclr   = 1'b1;
                    launch = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tcnt >= L_PROG && !init_ok) begin
                    st_n = ST_REL;
                    tclr = 1'b1;
                end else if (tcnt >= L_INIT) begin
                    fin_err   = 1'b1;
                    fin_cause = CAUSE_INIT_ASSERT;
                end
            end
            ST_REL: begin
                if (init_ok && !busy_s) begin
                    st_n = ST_SETTLE;
                    tclr = 1'b1;
                end else if (tcnt >= L_INIT) begin
                    fin_err   = 1'b1;
                    fin_cause = CAUSE_INIT_RELEASE;
                end
            end
            ST_SETTLE: begin
                if (tcnt >= L_SETTLE) st_n = ST_LOAD;
            end
            ST_LOAD: begin
                if (!init_ok) begin
                    fin_err   = 1'b1;
                    fin_cause = CAUSE_LOAD_ERR;
                end else if (s_valid) begin
                    st_n = ST_CLK_LO;
                end
            end
            ST_CLK_LO: st_n = ST_CLK_HI;
            ST_CLK_HI: begin
                if (CHECK_BUSY) begin
                    st_n = ST_BWAIT;
                    tclr = 1'b1;
                end else begin
                    st_n = last_q ? ST_DESEL : ST_LOAD;
                end
            end
            ST_BWAIT: begin
                if (!init_ok) begin
                    fin_err   = 1'b1;
                    fin_cause = CAUSE_LOAD_ERR;
                end else if (tcnt >= L_SYNC && !busy_s) begin
                    st_n = last_q ? ST_DESEL : ST_LOAD;
                end else if (tcnt >= L_BUSY) begin
                    fin_err   = 1'b1;
                    fin_cause = CAUSE_BUSY;
                end
            end
            ST_DESEL: st_n = ST_UNWR;
            ST_UNWR: begin
                st_n = ST_DWAIT;
                tclr = 1'b1;
            end
            ST_DWAIT: begin
                if (done_s && init_ok) begin
                    st_n   = ST_IDLE;
                    fin_ok = 1'b1;
                end else if (tcnt >= L_DONE) begin
                    fin_err   = 1'b1;
                    fin_cause = CAUSE_DONE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (fin_err) st_n = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Target pins, registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rst_n <= 1'b1;
            cfg_clk   <= 1'b1;
            cfg_sel_n <= 1'b1;
            cfg_wr_n  <= 1'b1;
        end else begin
            cfg_rst_n <= (st_n != ST_PULSE);
            cfg_clk   <= (st_n != ST_CLK_LO);
            cfg_sel_n <= !sel_on(st_n);
            cfg_wr_n  <= !wr_on(st_n);
        end
    end

    // Byte holding register and last-byte marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_data <= '0;
            last_q   <= 1'b0;
        end else if (accept) begin
            cfg_data <= s_data;
            last_q   <= s_last;
        end
    end

    // Run outcome, held until the next launch.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            ld_ok   <= 1'b0;
            ld_err  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (fin_ok) begin
            ld_ok   <= 1'b1;
        end else if (fin_err) begin
            ld_err  <= 1'b1;
            cause_q <= fin_cause;
        end
    end

    assign ld_active = (st != ST_IDLE);
    assign ld_cause  = cause_q;

endmodule

// File: rtl/cfg_loader.sv
// Module: parallel configuration loader, top level.
// Converts time-unit parameters to cycle counts, synchronizes the target
// status lines and ties the timer to the sequencing controller.
// Assumes CLK_HZ is a whole number of MHz.
module cfg_loader
    import cfg_ld_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned PROG_NS     = 300,
    parameter int unsigned INIT_TMO_US = 500_000,
    parameter int unsigned SETTLE_US   = 10_000,
    parameter int unsigned BUSY_TMO_US = 5_000,
    parameter int unsigned DONE_TMO_US = 200_000,
    parameter int          SYNC_STAGES = 2,
    parameter bit          CHECK_BUSY  = 1'b1,
    parameter int          DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    output logic          cfg_rst_n,
    output logic          cfg_clk,
    output logic          cfg_sel_n,
    output logic          cfg_wr_n,
    output logic [DW-1:0] cfg_data,
    input  logic          cfg_init_n,
    input  logic          cfg_busy,
    input  logic          cfg_done,
    output logic          ld_active,
    output logic          ld_ok,
    output logic          ld_err,
    output logic [2:0]    ld_cause
);

    localparam int unsigned PROG_CYC   = (ns_to_cyc(CLK_HZ, PROG_NS) < 1) ? 1 : ns_to_cyc(CLK_HZ, PROG_NS);
    localparam int unsigned INIT_CYC   = us_to_cyc(CLK_HZ, INIT_TMO_US);
    localparam int unsigned SETTLE_CYC = us_to_cyc(CLK_HZ, SETTLE_US);
    localparam int unsigned BUSY_CYC   = us_to_cyc(CLK_HZ, BUSY_TMO_US);
    localparam int unsigned DONE_CYC   = us_to_cyc(CLK_HZ, DONE_TMO_US);
    localparam int unsigned MAX_A      = (INIT_CYC > DONE_CYC) ? INIT_CYC : DONE_CYC;
    localparam int unsigned MAX_B      = (SETTLE_CYC > BUSY_CYC) ? SETTLE_CYC : BUSY_CYC;
    localparam int unsigned MAX_C      = (PROG_CYC > MAX_B) ? PROG_CYC : MAX_B;
    localparam int unsigned MAX_CYC    = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int          TW         = $clog2(MAX_CYC + 2);

    logic [2:0]    stat_s;
    logic [TW-1:0] tcnt;
    logic          tclr;

    cfg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cfg_done, cfg_busy, cfg_init_n}),
        .q     (stat_s)
    );

    cfg_timer #(
        .TW (TW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tclr),
        .cnt   (tcnt)
    );

    cfg_fsm #(
        .DW         (DW),
        .TW         (TW),
        .PROG_CYC   (PROG_CYC),
        .INIT_CYC   (INIT_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .BUSY_CYC   (BUSY_CYC),
        .DONE_CYC   (DONE_CYC),
        .SYNC_CYC   (SYNC_STAGES),
        .CHECK_BUSY (CHECK_BUSY)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .s_data    (s_data),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .init_ok   (stat_s[0]),
        .busy_s    (stat_s[1]),
        .done_s    (stat_s[2]),
        .tcnt      (tcnt),
        .tclr      (tclr),
        .cfg_rst_n (cfg_rst_n),
        .cfg_clk   (cfg_clk),
        .cfg_sel_n (cfg_sel_n),
        .cfg_wr_n  (cfg_wr_n),
        .cfg_data  (cfg_data),
        .ld_active (ld_active),
        .ld_ok     (ld_ok),
        .ld_err    (ld_err),
        .ld_cause  (ld_cause)
    );

endmodule

// File: rtl/cfg_loader_chk.sv
// Module: protocol checker for the configuration loader, bound to the top.
// Observes only the top-level ports.
module cfg_loader_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ready,
    input logic          cfg_rst_n,
    input logic          cfg_clk,
    input logic          cfg_sel_n,
    input logic          cfg_wr_n,
    input logic [DW-1:0] cfg_data,
    input logic          ld_ok,
    input logic          ld_err,
    input logic [2:0]    ld_cause
);

    AST_READY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (cfg_rst_n && !cfg_sel_n && !cfg_wr_n && cfg_clk)); // R5
    AST_CCLK_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clk) |=> cfg_clk); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> $stable(cfg_data)); // R5
    AST_CCLK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_clk |-> (!cfg_sel_n && !cfg_wr_n)); // R5
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n |-> (cfg_sel_n && cfg_wr_n && !s_ready)); // R2
    AST_SEL_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr_n) |-> cfg_sel_n); // R8
    AST_ERR_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_err |-> (cfg_rst_n && cfg_sel_n && cfg_wr_n)); // R9
    AST_ERR_CAUSE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ld_err |-> (ld_cause != 3'd0 && ld_cause <= 3'd5)); // R9
    AST_OK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok |-> (!ld_err && ld_cause == 3'd0)); // R9

endmodule

bind cfg_loader cfg_loader_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .cfg_rst_n (cfg_rst_n),
    .cfg_clk   (cfg_clk),
    .cfg_sel_n (cfg_sel_n),
    .cfg_wr_n  (cfg_wr_n),
    .cfg_data  (cfg_data),
    .ld_ok     (ld_ok),
    .ld_err    (ld_err),
    .ld_cause  (ld_cause)
);

// File: tb/test_cfg_loader.sv
// Bench: drives the loader against a behavioural target model and checks
// the outcome of each run from a vector table, then directed cases.
module test_cfg_loader;

    localparam int PROG_E   = 30;   // 300 ns at 100 MHz
    localparam int INIT_E   = 300;  // 3 us
    localparam int SETTLE_E = 100;  // 1 us

    typedef struct packed {
        int         n;
        int         mode;   // 0 healthy,1 init never low,2 init never high,3 crc fault,5 no done
        int         blen;   // busy cycles after each byte
        int         code;
        int         rx;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4, 0,   0, 0, 4, 8'h11},
        '{9, 0,   3, 0, 9, 8'hA7},
        '{1, 0,   0, 0, 1, 8'h3C},
        '{3, 1,   0, 1, 0, 8'h00},
        '{3, 2,   0, 2, 0, 8'h00},
        '{6, 3,   0, 3, 2, 8'h42},
        '{3, 0, 200, 4, 1, 8'h99},
        '{3, 5,   0, 5, 3, 8'h5E}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       cfg_rst_n, cfg_clk, cfg_sel_n, cfg_wr_n;
    logic [7:0] cfg_data;
    logic       tgt_init_n = 1'b1;
    logic       tgt_busy = 1'b0;
    logic       tgt_done = 1'b0;
    logic       ld_active, ld_ok, ld_err;
    logic [2:0] ld_cause;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cfg_loader #(
        .CLK_HZ      (100_000_000),
        .PROG_NS     (300),
        .INIT_TMO_US (3),
        .SETTLE_US   (1),
        .BUSY_TMO_US (1),
        .DONE_TMO_US (2),
        .SYNC_STAGES (2),
        .CHECK_BUSY  (1'b1),
        .DW          (8)
    ) i_cfg_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .s_data     (s_data),
        .s_valid    (s_valid),
        .s_last     (s_last),
        .s_ready    (s_ready),
        .cfg_rst_n  (cfg_rst_n),
        .cfg_clk    (cfg_clk),
        .cfg_sel_n  (cfg_sel_n),
        .cfg_wr_n   (cfg_wr_n),
        .cfg_data   (cfg_data),
        .cfg_init_n (tgt_init_n),
        .cfg_busy   (tgt_busy),
        .cfg_done   (tgt_done),
        .ld_active  (ld_active),
        .ld_ok      (ld_ok),
        .ld_err     (ld_err),
        .ld_cause   (ld_cause)
    );

    function automatic logic [7:0] pat(int i, logic [7:0] seed);
        return 8'(i * 37) ^ seed ^ 8'h5A;
    endfunction

    function automatic string req_of(int code);
        case (code)
            1: return "R2";
            2: return "R3";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Target model and measurements, evaluated away from the active edge.
    int m_n = 0, m_mode = 0, m_blen = 0;
    logic [7:0] m_seed = '0;
    int rx = 0, mism = 0, busy_cnt = 0, rel_cnt = 0;
    int prog_w = 0, nprog = 0, gap = 0, cyc = 0, sel_rise = 0, wr_rise = 0;
    logic gap_run = 1'b0;
    logic p_clk = 1'b1, p_rst = 1'b1, p_sel = 1'b1, p_wr = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !cfg_rst_n) begin
            prog_w++;
            if (p_rst) nprog++;
            tgt_init_n = (m_mode == 1);
            tgt_busy   = 1'b0;
            tgt_done   = 1'b0;
            busy_cnt   = 0;
            rel_cnt    = 0;
        end else if (rst_n) begin
            if (!p_rst) rel_cnt = 1;
            else if (rel_cnt >= 1 && rel_cnt < 5) rel_cnt++;
            else if (rel_cnt == 5) begin
                tgt_init_n = (m_mode != 2);
                rel_cnt    = 0;
            end
            if (cfg_clk && !p_clk && !cfg_sel_n && !cfg_wr_n) begin
                if (cfg_data != pat(rx, m_seed)) mism++;
                rx++;
                if (m_blen > 0) begin
                    tgt_busy = 1'b1;
                    busy_cnt = m_blen;
                end
                if (m_mode == 3 && rx == 2) tgt_init_n = 1'b0;
            end else if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) tgt_busy = 1'b0;
            end
            if (m_mode != 5 && m_mode != 3 && cfg_sel_n && cfg_wr_n &&
                rx == m_n && m_n > 0 && tgt_init_n)
                tgt_done = 1'b1;
        end
        if (!cfg_sel_n && p_sel) begin
            gap_run = 1'b1;
            gap     = 0;
        end else if (gap_run) begin
            if (!cfg_clk) gap_run = 1'b0;
            else          gap++;
        end
        if (cfg_sel_n && !p_sel) sel_rise = cyc;
        if (cfg_wr_n && !p_wr)   wr_rise  = cyc;
        p_clk = cfg_clk;
        p_rst = cfg_rst_n;
        p_sel = cfg_sel_n;
        p_wr  = cfg_wr_n;
    end

    // Byte stream source.
    int f_idx = 0, f_n = 0;
    logic [7:0] f_seed = '0;
    logic f_pend = 1'b0;

    always @(negedge clk) begin
        if (f_pend) f_idx++;
        s_valid = (f_idx < f_n);
        s_data  = pat(f_idx, f_seed);
        s_last  = (f_idx == f_n - 1);
        f_pend  = s_valid && s_ready;
    end

    task automatic setup_run(input int n, input int mode, input int blen,
                             input logic [7:0] seed);
        @(negedge clk);
        m_n = n; m_mode = mode; m_blen = blen; m_seed = seed;
        rx = 0; mism = 0; prog_w = 0; nprog = 0; gap = 0; gap_run = 1'b0;
        sel_rise = 0; wr_rise = 0;
        f_idx = 0; f_n = n; f_seed = seed; f_pend = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 6000 && ld_active; k++) @(negedge clk);
        if (ld_active) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 run watchdog: got active %0d expected %0d", 1, 0);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 global watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state while reset is held and right after release
        chk({cfg_rst_n, cfg_clk, cfg_sel_n, cfg_wr_n} == 4'hF, "R1", "pins in reset",
            int'({cfg_rst_n, cfg_clk, cfg_sel_n, cfg_wr_n}), 15);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({cfg_rst_n, cfg_clk, cfg_sel_n, cfg_wr_n} == 4'hF, "R1", "pins after reset",
            int'({cfg_rst_n, cfg_clk, cfg_sel_n, cfg_wr_n}), 15);
        chk({s_ready, ld_active, ld_ok, ld_err} == 4'h0 && ld_cause == 3'd0, "R1",
            "status after reset", int'({s_ready, ld_active, ld_ok, ld_err, ld_cause}), 0);

        for (int v = 0; v < 8; v++) begin
            setup_run(VECS[v].n, VECS[v].mode, VECS[v].blen, VECS[v].seed);
            pulse_start();
            wait_idle();
            @(negedge clk);
            chk(int'(ld_cause) == VECS[v].code, req_of(VECS[v].code), "cause code",
                int'(ld_cause), VECS[v].code);
            chk(ld_ok == (VECS[v].code == 0), "R9", "ok flag", int'(ld_ok),
                int'(VECS[v].code == 0));
            chk(ld_err == (VECS[v].code != 0), "R9", "err flag", int'(ld_err),
                int'(VECS[v].code != 0));
            chk(rx == VECS[v].rx, "R5", "bytes delivered", rx, VECS[v].rx);
            chk(mism == 0, "R5", "byte order/value mismatches", mism, 0);
            chk({cfg_rst_n, cfg_sel_n, cfg_wr_n} == 3'b111, "R9", "pins after run",
                int'({cfg_rst_n, cfg_sel_n, cfg_wr_n}), 7);
            if (VECS[v].code == 0) begin
                chk(prog_w >= PROG_E, "R2", "reset pulse width", prog_w, PROG_E);
                chk(gap >= SETTLE_E, "R4", "settle gap", gap, SETTLE_E);
                chk(wr_rise - sel_rise == 1, "R8", "deselect order", wr_rise - sel_rise, 1);
            end
            if (VECS[v].code == 1)
                chk(prog_w >= INIT_E, "R2", "init-assert timeout length", prog_w, INIT_E);
        end

        // R9: a new start clears the held error (last vector aborted)
        setup_run(4, 0, 0, 8'hC3);
        pulse_start();
        chk(!ld_err && ld_cause == 3'd0, "R9", "error cleared by start",
            int'({ld_err, ld_cause}), 0);
        // R10: start during the data phase is ignored
        for (int k = 0; k < 2000 && !s_ready; k++) @(negedge clk);
        pulse_start();
        wait_idle();
        @(negedge clk);
        chk(nprog == 1, "R10", "reset pulses in run", nprog, 1);
        chk(ld_ok && rx == 4, "R10", "run completed after stray start", rx, 4);

        summary();
        $finish;
    end

endmodule